// File: doc/BRIEF.md
# Chip-Select Timing Controller

This block is the timing engine for a single memory bank. Each bus access request is checked against a base address, with a mask choosing which upper address bits must agree. A matching request starts a timed sequence on four strobes: chip-select, write-enable, a data-buffer control strobe and a one-tick transfer-done pulse.

The block runs on a fast clock at four times the bus rate, so one tick is a quarter of a bus clock. That lets it place chip-select a quarter or half clock after the address and drop it a quarter clock early. A single option word sets the setup offset, the wait states, early negation, external termination, the read-hold idle time, the buffer disable and relaxed timing. The word is captured when an access is accepted. New requests are taken only while the controller is idle.

Option word layout (M = mask width, default 17): bits [M-1:0] mask, [M+1:M] setup code, [M+5:M+2] wait states, [M+6] early negation, [M+7] external termination, [M+9:M+8] read-hold code, [M+10] buffer disable, [M+11] relaxed timing.

Top module: `cs_timing_ctrl`

## Requirements
- R1: A request is accepted only if ((upper address bits XOR base) AND mask) is zero, where the upper bits are the top M bits of the address. A mask bit of 0 ignores that address bit. A request that does not match leaves busy low and every strobe inactive.
- R2: The chip-select setup delay, counted in ticks after the accepting edge, is set by the setup code: 00 gives 0, 10 gives 1 and 11 gives 2. The reserved code 01 behaves as 00.
- R3: The active phase, with chip-select asserted, lasts 4*(1+W) ticks, where W is the 4-bit wait-state field.
- R4: With the early-negation bit set, and an access ended by the internal counter, chip-select and write-enable negate one tick before the active phase ends.
- R5: With external termination clear, done pulses for one tick on the last tick of the active phase. If ext_ack arrives earlier in the active phase, done pulses on that tick and the access ends there.
- R6: With external termination set, the active phase lasts until ext_ack. Done pulses only on the tick where ext_ack is high.
- R7: After a read, the read-hold code adds idle ticks before the next access: 00 adds 0, 01 adds 4, 10 adds 16 and 11 adds 32. Writes add none.
- R8: The buffer strobe buf_n is low for the whole active phase unless the buffer-disable bit is set. When that bit is set, buf_n never goes low.
- R9: Relaxed timing doubles the setup delay and the wait-state count, and adds 4 hold ticks after every access.
- R10: we_n goes low only on writes, and exactly on the ticks where cs_n is low. Reads keep we_n high.
- R11: After reset all strobes are high, done is low and busy is low. Busy covers setup, active and hold. Requests made while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, four ticks per bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, sampled while idle |
| req_write | input | 1 | 1 for a write access |
| req_addr | input | ADDR_W | Access address |
| base_addr | input | MASK_W | Bank base, compared against the upper address bits |
| opt | input | MASK_W+12 | Option word |
| ext_ack | input | 1 | External acknowledge |
| cs_n | output | 1 | Chip-select, active low |
| we_n | output | 1 | Write-enable, active low |
| buf_n | output | 1 | Data-buffer control, active low |
| done | output | 1 | Transfer-done pulse |
| busy | output | 1 | Access or hold in progress |

## Verification
On every cycle the assertions check the following. Write-enable never appears without chip-select. No strobe is active outside busy. Done lasts one tick. With external termination, done never fires without the acknowledge. An idle controller with no request stays idle. The exact tick counts cannot be checked that way and only the bench scenarios show them: the setup offset, the active length, the early-negation tick, the read-hold length and the relaxed-timing extensions. The bench measures them against expected values computed from the option word.

// File: rtl/cs_timing_ctrl.sv
module cs_timing_ctrl #(
  parameter int ADDR_W = 32,
  parameter int MASK_W = 17,
  parameter int CNT_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [MASK_W-1:0] base_addr,
  input  logic [MASK_W+11:0] opt,
  input  logic              ext_ack,
  output logic              cs_n,
  output logic              we_n,
  output logic              buf_n,
  output logic              done,
  output logic              busy
);
  localparam int SU = MASK_W;
  localparam int WS = MASK_W + 2;
  localparam int NE = MASK_W + 6;
  localparam int ET = MASK_W + 7;
  localparam int RH = MASK_W + 8;
  localparam int BO = MASK_W + 10;
  localparam int RX = MASK_W + 11;
  localparam int OPT_W = MASK_W + 12;

  typedef enum logic [1:0] {IDLE, SETUP, ACT, HOLD} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic [OPT_W-1:0] opt_q;
  logic             wr_q;

  function automatic logic [CNT_W-1:0] su_len(input logic [OPT_W-1:0] o);
    logic [CNT_W-1:0] b;
    case (o[SU +: 2])
      2'b10:   b = CNT_W'(1);
      2'b11:   b = CNT_W'(2);
      default: b = '0;
    endcase
    return b << o[RX];
  endfunction

  function automatic logic [CNT_W-1:0] act_len(input logic [OPT_W-1:0] o);
    return ((CNT_W'(o[WS +: 4]) << o[RX]) + CNT_W'(1)) << 2;
  endfunction

  function automatic logic [CNT_W-1:0] hold_len(input logic [OPT_W-1:0] o, input logic wr);
    logic [CNT_W-1:0] h;
    case (o[RH +: 2])
      2'b01:   h = CNT_W'(4);
      2'b10:   h = CNT_W'(16);
      2'b11:   h = CNT_W'(32);
      default: h = '0;
    endcase
    if (wr) h = '0;
    return h + (o[RX] ? CNT_W'(4) : CNT_W'(0));
  endfunction

  wire hit   = (((req_addr[ADDR_W-1 -: MASK_W] ^ base_addr) & opt[MASK_W-1:0]) == '0);
  wire start = (st == IDLE) && req && hit;
  wire term  = (st == ACT) && (ext_ack || (!opt_q[ET] && cnt == '0));
  wire cs_on = (st == ACT) && !(opt_q[NE] && !opt_q[ET] && cnt == '0);

  logic [CNT_W-1:0] su_s, hl_s;
  assign su_s = su_len(opt);
  assign hl_s = hold_len(opt_q, wr_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= IDLE;
      cnt   <= '0;
      opt_q <= '0;
      wr_q  <= 1'b0;
    end else begin
      case (st)
        IDLE: if (start) begin
          opt_q <= opt;
          wr_q  <= req_write;
          if (su_s == '0) begin
            st  <= ACT;
            cnt <= act_len(opt) - CNT_W'(1);
          end else begin
            st  <= SETUP;
            cnt <= su_s - CNT_W'(1);
          end
        end
        SETUP: if (cnt == '0) begin
          st  <= ACT;
          cnt <= act_len(opt_q) - CNT_W'(1);
        end else cnt <= cnt - CNT_W'(1);
        ACT: if (term) begin
          if (hl_s == '0) st <= IDLE;
          else begin
            st  <= HOLD;
            cnt <= hl_s - CNT_W'(1);
          end
        end else if (cnt != '0) cnt <= cnt - CNT_W'(1);
        HOLD: if (cnt == '0) st <= IDLE;
          else cnt <= cnt - CNT_W'(1);
        default: st <= IDLE;
      endcase
    end
  end

  assign cs_n  = !cs_on;
  assign we_n  = !(cs_on && wr_q);
  assign buf_n = !((st == ACT) && !opt_q[BO]);
  assign done  = term;
  assign busy  = (st != IDLE);
endmodule

module cs_timing_ctrl_chk #(
  parameter int MASK_W = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req,
  input logic              ext_ack,
  input logic [MASK_W+11:0] opt_q,
  input logic              cs_n,
  input logic              we_n,
  input logic              buf_n,
  input logic              done,
  input logic              busy
);
  p_we_inside_cs_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !cs_n);
  p_cs_inside_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy);
  p_buf_inside_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !buf_n |-> busy);
  p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_ext_needs_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && opt_q[MASK_W+7] && !ext_ack) |-> !done);
  p_idle_holds_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !req) |=> !busy);
endmodule

bind cs_timing_ctrl cs_timing_ctrl_chk #(.MASK_W(MASK_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req(req), .ext_ack(ext_ack), .opt_q(opt_q),
  .cs_n(cs_n), .we_n(we_n), .buf_n(buf_n), .done(done), .busy(busy));

// File: tb/cs_timing_ctrl_tb_top.sv
module cs_timing_ctrl_tb_top;
  localparam int AW = 32;
  localparam int MW = 17;

  logic clk = 0, rst_n = 0, req = 0, req_write = 0, ext_ack = 0;
  logic [AW-1:0] req_addr = '0;
  logic [MW-1:0] base_addr = '0;
  logic [MW+11:0] opt = '0;
  logic cs_n, we_n, buf_n, done, busy;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  cs_timing_ctrl #(.ADDR_W(AW), .MASK_W(MW)) dut_i (.*);

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int e_setup(logic [MW+11:0] o);
    int b = (o[MW+1:MW] == 2'b10) ? 1 : (o[MW+1:MW] == 2'b11) ? 2 : 0;
    return o[MW+11] ? 2 * b : b;
  endfunction
  function automatic int e_act(logic [MW+11:0] o);
    return 4 * (1 + int'(o[MW+5:MW+2]) * (o[MW+11] ? 2 : 1));
  endfunction
  function automatic int e_hold(logic [MW+11:0] o, logic wr);
    int h = 0;
    if (!wr) h = (o[MW+9:MW+8] == 2'b01) ? 4 : (o[MW+9:MW+8] == 2'b10) ? 16 :
                 (o[MW+9:MW+8] == 2'b11) ? 32 : 0;
    return h + (o[MW+11] ? 4 : 0);
  endfunction

  function automatic logic [AW-1:0] hit_addr(logic [MW-1:0] b, logic [MW-1:0] m);
    logic [MW-1:0] up = (b & m) | (MW'($urandom) & ~m);
    return {up, (AW-MW)'($urandom)};
  endfunction

  // ack_at: sample index of ext_ack (0 = none); mid_req: pulse a hit request while busy
  task automatic run(logic [MW+11:0] o, logic wr, int ack_at, bit mid_req);
    int s = e_setup(o), l = e_act(o), h, fin, cs_c = 0, we_c = 0, buf_c = 0;
    int done_c = 0, done_at = -1, first_cs = -1, bsy = 0, neg;
    logic [AW-1:0] a;
    @(negedge clk);
    opt = o; req_write = wr; a = hit_addr(base_addr, o[MW-1:0]); req_addr = a; req = 1;
    @(negedge clk);
    req = 0;
    for (int i = 1; i < 400; i++) begin
      ext_ack = (i == ack_at);
      if (mid_req) req = (i == 2);
      #1;
      if (!busy) break;
      bsy++;
      if (!cs_n) begin cs_c++; if (first_cs < 0) first_cs = i; end
      if (!we_n) we_c++;
      if (!buf_n) buf_c++;
      if (done) begin done_c++; done_at = i; end
      @(negedge clk);
    end
    ext_ack = 0; req = 0;
    if (o[MW+7]) fin = ack_at;
    else fin = (ack_at > s && ack_at < s + l) ? ack_at : s + l;
    neg = (o[MW+6] && !o[MW+7] && fin == s + l) ? 1 : 0;
    h = e_hold(o, wr);
    chk("R2 setup", first_cs, s + 1);
    chk("R3 cs ticks", cs_c, fin - s - neg);
    chk("R4 negation", cs_c + neg, fin - s);
    chk(o[MW+7] ? "R6 done tick" : "R5 done tick", done_at, fin);
    chk("R5 done count", done_c, 1);
    chk("R10 we ticks", we_c, wr ? fin - s - neg : 0);
    chk("R8 buf ticks", buf_c, o[MW+10] ? 0 : fin - s);
    chk(o[MW+11] ? "R9 busy len" : "R7 busy len", bsy, fin + h);
    if (mid_req) chk("R11 ignore busy req", int'(busy), 0);
  endtask

  function automatic logic [MW+11:0] mk(logic [MW-1:0] m, logic [1:0] su, logic [3:0] ws,
      logic ne, logic et, logic [1:0] rh, logic bo, logic rx);
    return {rx, bo, rh, et, ne, ws, su, m};
  endfunction

  initial begin
    #1_500_000;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    #1;
    chk("R11 reset cs", int'(cs_n), 1);
    chk("R11 reset we", int'(we_n), 1);
    chk("R11 reset buf", int'(buf_n), 1);
    chk("R11 reset done", int'(done), 0);
    chk("R11 reset busy", int'(busy), 0);
    #20 rst_n = 1;
    base_addr = 17'h0A5C3;

    // R1: mismatch on a compared bit
    @(negedge clk);
    opt = mk(17'h1FF00, 2'b00, 4'd0, 0, 0, 2'b00, 0, 0);
    req_addr = {base_addr ^ 17'h00100, 15'h0}; req = 1;
    @(negedge clk); req = 0; #1;
    chk("R1 miss ignored", int'(busy), 0);
    chk("R1 miss no cs", int'(cs_n), 1);
    // R1: differing bit masked off is a hit
    @(negedge clk);
    req_addr = {base_addr ^ 17'h00001, 15'h0}; req = 1;
    @(negedge clk); req = 0; #1;
    chk("R1 masked hit", int'(busy), 1);
    repeat (8) @(negedge clk);

    run(mk(17'h1FFFF, 2'b01, 4'd0, 0, 0, 2'b00, 0, 0), 0, 0, 0);
    run(mk(17'h1FFFF, 2'b10, 4'd2, 0, 0, 2'b01, 0, 0), 1, 0, 0);
    run(mk(17'h1FFFF, 2'b11, 4'd15, 1, 0, 2'b11, 0, 0), 0, 0, 0);
    run(mk(17'h0F0F0, 2'b11, 4'd3, 1, 0, 2'b10, 1, 1), 1, 0, 1);
    run(mk(17'h1FFFF, 2'b10, 4'd5, 1, 0, 2'b10, 0, 0), 0, 4, 0);
    run(mk(17'h1FFFF, 2'b00, 4'd0, 1, 1, 2'b00, 0, 0), 1, 12, 0);
    run(mk(17'h00000, 2'b11, 4'd1, 0, 0, 2'b11, 0, 1), 0, 0, 1);

    for (int k = 0; k < 60; k++) begin
      logic [MW+11:0] o = mk(MW'($urandom), 2'($urandom), 4'($urandom), 1'($urandom),
                             1'($urandom), 2'($urandom), 1'($urandom), 1'($urandom));
      int s = e_setup(o), l = e_act(o), ack;
      if (o[MW+7]) ack = s + 1 + int'($urandom_range(0, l + 4));
      else ack = ($urandom_range(0, 2) == 0) ? s + 1 + int'($urandom_range(0, l - 1)) : 0;
      run(o, 1'($urandom), ack, 1'($urandom));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule